// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character into an asynchronous serial frame on a single transmit line. The frame layout is chosen at run time: 5 to 8 data bits, an optional parity bit of four kinds, an optional user-supplied extra bit used when parity is off, and a short or long stop period. Timing comes from an external enable that pulses once per sixteenth of a bit time. Every bit therefore lasts 16 of these sub-ticks, and a half bit lasts 8.

Characters enter through a valid/ready stream port. A character is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The source must then hold `in_data`, `in_extra` and the configuration pins steady until that edge. While `in_ready` is low, the source waits and nothing is consumed. The configuration pins are captured in the same edge as the character, and changes on them during the frame have no effect.

`in_ready` stays low from acceptance until the last sub-tick of the stop period begins. A character offered at that point starts on the next tick, so frames can follow each other with no idle gap. `busy` is high whenever a frame is pending or in flight, except during that last stop sub-tick.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `tx_line` is 1, `in_ready` is 1 and `busy` is 0, and the line stays at 1 whenever no frame is being sent.
- R2: A frame starts with a low start bit of 16 ticks. The data bits follow, least significant first, each 16 ticks long. The number of data bits is 5 + `cfg_len` (0→5, 1→6, 2→7, 3→8), and the unused upper bits of `in_data` are never sent.
- R3: With `cfg_parity_en`=1, one parity bit follows the data. For `cfg_parity_kind` 0 it makes the number of ones in the sent data plus parity even, and for 1 it makes that number odd. Only the selected data bits are counted.
- R4: `cfg_parity_kind` 2 sends a parity bit that is always 1, and 3 sends one that is always 0.
- R5: With `cfg_parity_en`=0 and `cfg_extra_en`=1, the value of `in_extra` is sent as one bit after the data. With both at 0, the stop period follows the data directly.
- R6: When `cfg_parity_en`=1, `cfg_extra_en` and `in_extra` have no effect. Exactly one bit, the parity bit, sits between the data and the stop period.
- R7: The stop period is high. It lasts 16 ticks with `cfg_long_stop`=0, and 32 ticks with `cfg_long_stop`=1 for 6, 7 or 8 data bits.
- R8: With `cfg_long_stop`=1 and 5 data bits, the stop period lasts 24 ticks (one and a half bits).
- R9: `in_ready` drops in the cycle after acceptance and returns when the last stop tick begins. A character waiting at that point starts its start bit on the next tick, so the start bit follows the stop period with no gap.
- R10: The configuration is captured at acceptance. Changing the configuration pins or data during a frame does not alter that frame.
- R11: `tx_line` changes only on clock edges where `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Sub-bit timing enable, 16 per bit time |
| cfg_len | input | 2 | Data length code, length = 5 + code |
| cfg_parity_en | input | 1 | Insert a parity bit after the data |
| cfg_parity_kind | input | 2 | 0 even, 1 odd, 2 always 1, 3 always 0 |
| cfg_extra_en | input | 1 | Insert `in_extra` after the data when parity is off |
| cfg_long_stop | input | 1 | Long stop period (1.5 or 2 bits) |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can take a character |
| in_data | input | 8 | Character, least significant bit sent first |
| in_extra | input | 1 | Value for the extra bit |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame pending or being sent |

## Verification
A wrong bit-position count or a wrong shift in the serializer shows at the line within one bit time of the fault, as a level that differs from the expected frame. A wrong parity or extra-bit decision shows within the bit after the last data bit. A stop counter loaded with the wrong length does not change the line level. Instead it moves the next start edge or the release of `in_ready`, which becomes visible only when a second character is already waiting. For that reason, consecutive frames are compared both by their start spacing and by the sampled levels.

// File: rtl/uft_pkg.sv
package uft_pkg;
  localparam int DATA_W  = 8;
  localparam int LEN_MIN = 5;
  localparam int WORD_W  = DATA_W + 1;

  typedef enum logic [1:0] {
    PK_EVEN  = 2'd0,
    PK_ODD   = 2'd1,
    PK_ONE   = 2'd2,
    PK_ZERO  = 2'd3
  } parity_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2,
    ST_STOP = 2'd3
  } tx_state_e;
endpackage

// File: rtl/uft_format.sv
// Builds the per-frame word (data bits then the optional middle bit),
// the number of bit slots after the start bit, and the stop length.
module uft_format
  import uft_pkg::*;
#(
  parameter int OS     = 16,
  parameter int STOP_W = $clog2(2 * OS),
  parameter int SLOT_W = 4
) (
  input  logic [DATA_W-1:0] data,
  input  logic              extra,
  input  logic [1:0]        len_code,
  input  logic              par_en,
  input  logic [1:0]        par_kind,
  input  logic              extra_en,
  input  logic              long_stop,
  output logic [WORD_W-1:0] word,
  output logic [SLOT_W-1:0] slots,
  output logic [STOP_W-1:0] stop_m1
);
  localparam int SHORT_STOP = OS;
  localparam int HALF_STOP  = OS + OS / 2;
  localparam int FULL_STOP  = 2 * OS;

  logic [SLOT_W-1:0] n_bits;
  logic [DATA_W-1:0] keep;
  logic [DATA_W-1:0] kept;
  logic              ones_odd;
  logic              mid_bit;
  logic              mid_on;
  parity_kind_e      kind;

  assign n_bits = SLOT_W'(LEN_MIN) + SLOT_W'(len_code);
  assign kind   = parity_kind_e'(par_kind);

  for (genvar i = 0; i < DATA_W; i++) begin : g_keep
    assign keep[i] = (SLOT_W'(i) < n_bits);
  end

  assign kept     = data & keep;
  assign ones_odd = ^kept;
  assign mid_on   = par_en | extra_en;

  always_comb begin
    if (par_en) begin
      unique case (kind)
        PK_EVEN: mid_bit = ones_odd;
        PK_ODD:  mid_bit = ~ones_odd;
        PK_ONE:  mid_bit = 1'b1;
        default: mid_bit = 1'b0;
      endcase
    end else begin
      mid_bit = extra;
    end
  end

  always_comb begin
    word = '1;
    for (int i = 0; i < DATA_W; i++) begin
      if (keep[i]) word[i] = data[i];
    end
    word[n_bits] = mid_bit;
  end

  assign slots = n_bits + SLOT_W'(mid_on);

  always_comb begin
    if (!long_stop)          stop_m1 = STOP_W'(SHORT_STOP - 1);
    else if (len_code == '0) stop_m1 = STOP_W'(HALF_STOP - 1);
    else                     stop_m1 = STOP_W'(FULL_STOP - 1);
  end
endmodule

// File: rtl/uft_serializer.sv
// Frame sequencer: handshake, start bit, word shifting, stop countdown.
module uft_serializer
  import uft_pkg::*;
#(
  parameter int OS     = 16,
  parameter int STOP_W = $clog2(2 * OS),
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] word,
  input  logic [SLOT_W-1:0] slots,
  input  logic [STOP_W-1:0] stop_m1,
  output logic              tx_line,
  output logic              busy
);
  localparam int SUB_W = $clog2(OS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OS - 1);

  tx_state_e         st_q;
  logic [WORD_W-1:0] sh_q;
  logic [SLOT_W-1:0] left_q;
  logic [SUB_W-1:0]  sub_q;
  logic [STOP_W-1:0] stop_len_q;
  logic [STOP_W-1:0] stop_rem_q;
  logic              line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      sh_q       <= '1;
      left_q     <= '0;
      sub_q      <= '0;
      stop_len_q <= '0;
      stop_rem_q <= '0;
      line_q     <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (in_valid) begin
            sh_q       <= word;
            left_q     <= slots;
            stop_len_q <= stop_m1;
            st_q       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tick_en) begin
            line_q <= 1'b0;
            sub_q  <= '0;
            st_q   <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tick_en) begin
            if (sub_q == SUB_LAST) begin
              sub_q <= '0;
              if (left_q != '0) begin
                line_q <= sh_q[0];
                sh_q   <= {1'b1, sh_q[WORD_W-1:1]};
                left_q <= left_q - 1'b1;
              end else begin
                line_q     <= 1'b1;
                stop_rem_q <= stop_len_q;
                st_q       <= ST_STOP;
              end
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
        end
        default: begin
          if (tick_en) begin
            if (stop_rem_q == STOP_W'(1)) st_q <= ST_IDLE;
            else                          stop_rem_q <= stop_rem_q - 1'b1;
          end
        end
      endcase
    end
  end

  assign in_ready = (st_q == ST_IDLE);
  assign busy     = (st_q != ST_IDLE);
  assign tx_line  = line_q;

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE || st_q == ST_WAIT) |-> tx_line);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && tick_en) |=> !tx_line);

  assert_slot_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= SLOT_W'(WORD_W));

  assert_stop_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STOP) |-> tx_line);

  assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(stop_len_q));

  assert_tick_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(tx_line));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic [1:0]  cfg_len,
  input  logic        cfg_parity_en,
  input  logic [1:0]  cfg_parity_kind,
  input  logic        cfg_extra_en,
  input  logic        cfg_long_stop,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_extra,
  output logic        tx_line,
  output logic        busy
);
  localparam int STOP_W = $clog2(2 * OVERSAMPLE);
  localparam int SLOT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] word;
  logic [SLOT_W-1:0] slots;
  logic [STOP_W-1:0] stop_m1;

  uft_format #(.OS(OVERSAMPLE), .STOP_W(STOP_W), .SLOT_W(SLOT_W)) u_format (
    .data      (in_data),
    .extra     (in_extra),
    .len_code  (cfg_len),
    .par_en    (cfg_parity_en),
    .par_kind  (cfg_parity_kind),
    .extra_en  (cfg_extra_en),
    .long_stop (cfg_long_stop),
    .word      (word),
    .slots     (slots),
    .stop_m1   (stop_m1)
  );

  uft_serializer #(.OS(OVERSAMPLE), .STOP_W(STOP_W), .SLOT_W(SLOT_W)) u_serializer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .word     (word),
    .slots    (slots),
    .stop_m1  (stop_m1),
    .tx_line  (tx_line),
    .busy     (busy)
  );
endmodule

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_parity_en = 1'b0;
  logic [1:0] cfg_parity_kind = 2'd0;
  logic       cfg_extra_en = 1'b0;
  logic       cfg_long_stop = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_extra = 1'b0;
  logic       tx_line;
  logic       busy;

  int checks = 0;
  int fails  = 0;
  logic [1:0] tdiv = 2'd0;
  logic       tick_d = 1'b0;

  bit    exp_q[$];
  int    len_q[$];
  string tag_q[$];
  int    starts[$];
  int    remain = 0, tick_no = 0, stab_err = 0, sent_n = 0;
  int    pos = 0, bad_pos = -1;
  bit    bad_act, bad_exp, last_tx = 1'b1;
  string cur_tag = "";
  bit    done = 1'b0;

  always #2 clk = ~clk;

  assign tick_en = (tdiv == 2'd3);
  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick_d <= tick_en;
  end

  uart_frame_tx i_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_len(cfg_len),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_kind(cfg_parity_kind),
    .cfg_extra_en(cfg_extra_en), .cfg_long_stop(cfg_long_stop),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_extra(in_extra), .tx_line(tx_line), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Monitor: samples the line once per tick and compares against the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (!tick_d) begin
        if (tx_line !== last_tx) stab_err++;
      end else begin
        tick_no++;
        if (remain == 0 && tx_line == 1'b0) begin
          if (len_q.size() == 0) begin
            check(1'b0, "R1 unexpected start", 0, 1);
          end else begin
            remain  = len_q.pop_front();
            cur_tag = tag_q.pop_front();
            starts.push_back(tick_no);
            pos = 0;
            bad_pos = -1;
          end
        end
        if (remain > 0) begin
          bit e;
          e = exp_q.pop_front();
          if (tx_line !== e && bad_pos < 0) begin
            bad_pos = pos;
            bad_act = tx_line;
            bad_exp = e;
          end
          pos++;
          remain--;
          if (remain == 0) begin
            checks++;
            if (bad_pos >= 0) begin
              fails++;
              $display("FAIL %s: sub-tick %0d actual %0d expected %0d",
                       cur_tag, bad_pos, bad_act, bad_exp);
            end
          end
        end
      end
      last_tx = tx_line;
    end
  end

  function automatic int frame_len(input int n, input bit pe, input bit xe, input bit ls);
    int stop_t;
    stop_t = !ls ? 16 : (n == 5 ? 24 : 32);
    return 16 * (1 + n + ((pe || xe) ? 1 : 0)) + stop_t;
  endfunction

  // Driver: pushes the expected frame, then offers the character.
  task automatic send(input logic [7:0] d, input bit x, input int n, input bit pe,
                      input logic [1:0] pk, input bit xe, input bit ls, input bit scr,
                      input string tag, output int flen);
    bit ones;
    bit mid;
    ones = 1'b0;
    for (int i = 0; i < n; i++) ones ^= d[i];
    case (pk)
      2'd0: mid = ones;
      2'd1: mid = ~ones;
      2'd2: mid = 1'b1;
      default: mid = 1'b0;
    endcase
    if (!pe) mid = x;
    flen = frame_len(n, pe, xe, ls);
    for (int k = 0; k < 16; k++) exp_q.push_back(1'b0);
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 16; k++) exp_q.push_back(d[i]);
    if (pe || xe)
      for (int k = 0; k < 16; k++) exp_q.push_back(mid);
    for (int k = 0; k < flen - 16 * (1 + n + ((pe || xe) ? 1 : 0)); k++)
      exp_q.push_back(1'b1);
    len_q.push_back(flen);
    tag_q.push_back(tag);
    sent_n++;

    cfg_len = 2'(n - 5);
    cfg_parity_en = pe;
    cfg_parity_kind = pk;
    cfg_extra_en = xe;
    cfg_long_stop = ls;
    in_data = d;
    in_extra = x;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R9 ready low after accept", int'(in_ready), 0);
    in_valid = 1'b0;
    if (scr) begin
      // R10: disturb every configuration pin during the frame
      cfg_len = ~cfg_len;
      cfg_parity_en = ~cfg_parity_en;
      cfg_parity_kind = ~cfg_parity_kind;
      cfg_extra_en = ~cfg_extra_en;
      cfg_long_stop = ~cfg_long_stop;
      in_data = ~in_data;
      in_extra = ~in_extra;
    end
  endtask

  task automatic drain();
    while (len_q.size() != 0 || remain != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int l0, l1, l2, i0;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(tx_line == 1'b1, "R1 line idle", int'(tx_line), 1);
    check(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check(tx_line == 1'b1 && stab_err == 0, "R1 idle after reset", int'(tx_line), 1);

    // R2: lengths 5..8, LSB first, upper bits not sent
    send(8'hA5, 1'b0, 8, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R2 len8", l0);
    send(8'hF3, 1'b0, 5, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R2 len5", l0);
    send(8'hC6, 1'b0, 6, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R2 len6", l0);
    send(8'h59, 1'b0, 7, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R2 len7", l0);
    // R3: even/odd over selected bits only
    send(8'hB7, 1'b0, 8, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, "R3 even len8", l0);
    send(8'hE1, 1'b0, 5, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, "R3 even masked len5", l0);
    send(8'h01, 1'b0, 5, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, "R3 odd len5", l0);
    send(8'h3C, 1'b0, 7, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, "R3 odd len7", l0);
    // R4: fixed parity values
    send(8'h00, 1'b0, 7, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, "R4 mark", l0);
    send(8'hFF, 1'b0, 6, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, "R4 space", l0);
    // R5: extra bit
    send(8'h81, 1'b1, 8, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, "R5 extra one", l0);
    send(8'h7E, 1'b0, 6, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, "R5 extra zero", l0);
    // R6: extra ignored under parity
    send(8'h03, 1'b1, 8, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, "R6 extra ignored", l0);
    // R7 and R8: stop lengths
    send(8'h55, 1'b0, 8, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R7 long len8", l0);
    send(8'h0A, 1'b0, 5, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R8 long len5", l0);
    send(8'h15, 1'b0, 5, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, "R8 long len5 parity", l0);
    drain();

    // R9: back-to-back spacing, start follows stop with no gap
    i0 = sent_n;
    send(8'h96, 1'b0, 5, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R9 pair a", l0);
    send(8'h2D, 1'b1, 8, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, "R9 pair b", l1);
    send(8'hC3, 1'b0, 6, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, "R9 pair c", l2);
    drain();
    check(starts[i0 + 1] - starts[i0] == l0, "R9 gap after 1.5 stop",
          starts[i0 + 1] - starts[i0], l0);
    check(starts[i0 + 2] - starts[i0 + 1] == l1, "R9 gap after 2 stop",
          starts[i0 + 2] - starts[i0 + 1], l1);

    // R10: configuration and data changed mid-frame
    send(8'h6B, 1'b1, 7, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, "R10 scrambled a", l0);
    send(8'h94, 1'b0, 5, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, "R10 scrambled b", l0);
    drain();
    check(busy == 1'b0 && in_ready == 1'b1, "R1 idle after frames", int'(busy), 0);

    // R11: line moved only on tick edges
    check(stab_err == 0, "R11 change without tick", stab_err, 0);
    finish_run();
  end
endmodule